// File: doc/BRIEF.md
# Startup Reset and Divider Sequencer

This block takes a small processor system out of its global reset. A free-running binary divider starts counting as soon as the global reset is released. Its most significant bit marks the end of the oscillator settling time. That bit is combined with a clock-enable handshake latch, set by the processor, to form an oscillator-stable flag. Two test inputs can force the flag high directly: the flag is high whenever they differ.

A small state machine turns the first assertion of the stable flag into the release of a synchronous processor reset. After release, the reset stays low until the next global reset, whatever the flag does. The divider is cleared in three cases: by the global reset, by a processor write to the divider address, and by a high-to-low transition of the stable flag. The upper bits of the divider are always visible on a read-data output.

The state machine has three states:
- `ST_RESET` is held while the global reset is asserted. It always moves to `ST_SETTLE` on the first clock edge after release.
- `ST_SETTLE` keeps the processor in reset. It moves to `ST_RUN` on the first edge where the stable flag is high.
- `ST_RUN` releases the processor. Only the global reset leaves it, which returns the machine to `ST_RESET`.

Top module: `boot_reset_seq`

## Requirements
- R1: While and right after the global reset, `cpu_sync_rst` is 1 and `div_hi` is 0. In that state `osc_stable` equals `tst_a ^ tst_b`.
- R2: `osc_stable` = (`tst_a` XOR `tst_b`) OR (divider bit DIV_W-1 AND NOT the clock-enable latch), evaluated combinationally from the current inputs and state.
- R3: The clock-enable latch is set at a clock edge where `cpu_clk_req` is 1. It is cleared at an edge where `osc_en` is 0, and the clear wins over a simultaneous set. The global reset also clears it. The latch is observed through `osc_stable` while the divider top bit is 1 and the test inputs are equal.
- R4: Outside the clear cases, the divider advances by exactly one on every clock edge and wraps modulo 2^DIV_W. `div_hi` shows divider bits DIV_W-1 down to DIV_W-RD_W.
- R5: A divider write is `cpu_wr`=1, `tim_sel`=1 and `addr_bits`=2'b00 together, where `addr_bits` carries address bits 2 and 1. A write clears the divider at that clock edge. With `tim_sel`=0 or `addr_bits`≠2'b00, the write has no effect on the count.
- R6: If `osc_stable` was 1 at the previous edge and is 0 at the current edge, the divider is cleared at the current edge.
- R7: `cpu_sync_rst` stays 1 from global reset until the first clock edge, after the edge that leaves reset, at which `osc_stable` is 1. With the test inputs equal, it therefore falls one cycle after the divider top bit first rises. Once low, it stays low until the next global reset, even if `osc_stable` falls.
- R8: While `rst_glob` is 1 the divider is held at zero and does not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_glob | input | 1 | Global reset, active high, asynchronous assert |
| osc_en | input | 1 | Oscillator enable; low clears the clock-enable latch |
| cpu_clk_req | input | 1 | Processor clock-enable request; sets the latch |
| tst_a | input | 1 | Test input A |
| tst_b | input | 1 | Test input B |
| cpu_wr | input | 1 | Processor write strobe |
| tim_sel | input | 1 | Decoded select of the timer register group |
| addr_bits | input | 2 | Processor address bits 2 and 1 |
| cpu_sync_rst | output | 1 | Synchronous processor reset, active high |
| osc_stable | output | 1 | Oscillator-stable flag |
| div_hi | output | RD_W | Upper bits of the divider for reads |

## Verification
The assertions assume that `rst_glob` is the only asynchronous input. All other inputs are taken to change away from the rising clock edge, so that the stable flag, the write decode and the latch set and clear are all settled when they are sampled. The bench drives every input on the falling edge and holds it across the following rising edge. The divider is shortened to 8 bits so that its top bit rises within 128 cycles. The bench walks through the first release, writes that hit and miss the divider address, the latch set and clear race, and a flag drop caused by the test inputs.

// File: rtl/boot_seq_pkg.sv
`timescale 1ns/1ps
package boot_seq_pkg;

    // Release sequence of the processor reset.
    typedef enum logic [1:0] {
        ST_RESET  = 2'd0,
        ST_SETTLE = 2'd1,
        ST_RUN    = 2'd2
    } boot_state_t;

    // Default width of the read-back window of the divider.
    localparam int unsigned DEF_RD_W = 8;

    // Decode of a processor write aimed at the divider register.
    function automatic logic div_write_hit(input logic wr,
                                           input logic sel,
                                           input logic [1:0] abits);
        return wr && sel && (abits == 2'b00);
    endfunction

endpackage

// File: rtl/bsq_hold_latch.sv
`timescale 1ns/1ps
// Clock-enable handshake latch, modelled as a flop with clear priority.
module bsq_hold_latch (
    input  logic clk,
    input  logic rst_glob,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);

    always_ff @(posedge clk or posedge rst_glob) begin
        if (rst_glob) begin
            q_o <= 1'b0;
        end else if (clr_i) begin
            q_o <= 1'b0;
        end else if (set_i) begin
            q_o <= 1'b1;
        end
    end

    p_set_r3: assert property (@(posedge clk) disable iff (rst_glob)
        (set_i && !clr_i) |=> q_o);

    p_clr_r3: assert property (@(posedge clk) disable iff (rst_glob)
        clr_i |=> !q_o);

endmodule

// File: rtl/bsq_divider.sv
`timescale 1ns/1ps
// Free-running binary divider with a synchronous clear.
module bsq_divider #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_glob,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk or posedge rst_glob) begin
        if (rst_glob) begin
            cnt_o <= '0;
        end else if (clr_i) begin
            cnt_o <= '0;
        end else begin
            cnt_o <= cnt_o + ONE;
        end
    end

    p_step_r4: assert property (@(posedge clk) disable iff (rst_glob)
        !clr_i |=> (cnt_o == $past(cnt_o) + ONE));

endmodule

// File: rtl/bsq_osc_mon.sv
`timescale 1ns/1ps
// Forms the oscillator-stable flag and flags its high-to-low transition.
module bsq_osc_mon (
    input  logic clk,
    input  logic rst_glob,
    input  logic tst_a,
    input  logic tst_b,
    input  logic div_top,
    input  logic hold,
    output logic stable_o,
    output logic fall_o
);

    logic stable_prev;

    always_comb begin
        stable_o = (tst_a ^ tst_b) | (div_top & ~hold);
        fall_o   = stable_prev & ~stable_o;
    end

    always_ff @(posedge clk or posedge rst_glob) begin
        if (rst_glob) begin
            stable_prev <= 1'b0;
        end else begin
            stable_prev <= stable_o;
        end
    end

endmodule

// File: rtl/bsq_reset_fsm.sv
`timescale 1ns/1ps
// Release sequencer for the synchronous processor reset.
module bsq_reset_fsm
    import boot_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_glob,
    input  logic stable_i,
    output logic sync_rst_o
);

    boot_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESET:  state_d = ST_SETTLE;
            ST_SETTLE: if (stable_i) state_d = ST_RUN;
            ST_RUN:    state_d = ST_RUN;
            default:   state_d = ST_RESET;
        endcase
    end

    always_ff @(posedge clk or posedge rst_glob) begin
        if (rst_glob) begin
            state_q <= ST_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        sync_rst_o = (state_q != ST_RUN);
    end

    p_run_sticky_r7: assert property (@(posedge clk) disable iff (rst_glob)
        (state_q == ST_RUN) |=> (state_q == ST_RUN));

    p_release_r7: assert property (@(posedge clk) disable iff (rst_glob)
        $fell(sync_rst_o) |-> $past(stable_i));

endmodule

// File: rtl/boot_reset_seq.sv
`timescale 1ns/1ps
// Startup reset and divider sequencer, top level.
module boot_reset_seq
    import boot_seq_pkg::*;
#(
    parameter int unsigned DIV_W = 16,
    parameter int unsigned RD_W  = DEF_RD_W
) (
    input  logic            clk,
    input  logic            rst_glob,
    input  logic            osc_en,
    input  logic            cpu_clk_req,
    input  logic            tst_a,
    input  logic            tst_b,
    input  logic            cpu_wr,
    input  logic            tim_sel,
    input  logic [1:0]      addr_bits,
    output logic            cpu_sync_rst,
    output logic            osc_stable,
    output logic [RD_W-1:0] div_hi
);

    localparam int unsigned TOP = DIV_W - 1;

    logic [DIV_W-1:0] div_q;
    logic             hold_q;
    logic             osc_fall;
    logic             div_wr;
    logic             div_clr;

    always_comb begin
        div_wr  = div_write_hit(cpu_wr, tim_sel, addr_bits);
        div_clr = div_wr | osc_fall;
    end

    bsq_hold_latch u_hold (
        .clk      (clk),
        .rst_glob (rst_glob),
        .set_i    (cpu_clk_req),
        .clr_i    (~osc_en),
        .q_o      (hold_q)
    );

    bsq_divider #(.W(DIV_W)) u_div (
        .clk      (clk),
        .rst_glob (rst_glob),
        .clr_i    (div_clr),
        .cnt_o    (div_q)
    );

    bsq_osc_mon u_mon (
        .clk      (clk),
        .rst_glob (rst_glob),
        .tst_a    (tst_a),
        .tst_b    (tst_b),
        .div_top  (div_q[TOP]),
        .hold     (hold_q),
        .stable_o (osc_stable),
        .fall_o   (osc_fall)
    );

    bsq_reset_fsm u_fsm (
        .clk        (clk),
        .rst_glob   (rst_glob),
        .stable_i   (osc_stable),
        .sync_rst_o (cpu_sync_rst)
    );

    generate
        if (DIV_W >= RD_W) begin : g_rd_slice
            assign div_hi = div_q[TOP -: RD_W];
        end else begin : g_rd_pad
            assign div_hi = {{(RD_W - DIV_W){1'b0}}, div_q};
        end
    endgenerate

    p_wrclr_r5: assert property (@(posedge clk) disable iff (rst_glob)
        div_wr |=> (div_q == '0));

    p_fall_clr_r6: assert property (@(posedge clk) disable iff (rst_glob)
        osc_fall |=> (div_q == '0));

endmodule

// File: tb/sim_boot_reset_seq.sv
`timescale 1ns/1ps
module sim_boot_reset_seq;

    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_glob = 1'b1;
    logic osc_en = 1'b1;
    logic cpu_clk_req = 1'b0;
    logic tst_a = 1'b0;
    logic tst_b = 1'b0;
    logic cpu_wr = 1'b0;
    logic tim_sel = 1'b0;
    logic [1:0] addr_bits = 2'b00;
    logic cpu_sync_rst;
    logic osc_stable;
    logic [W-1:0] div_hi;

    int checks = 0;
    int failures = 0;
    string cur_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    boot_reset_seq #(.DIV_W(W), .RD_W(W)) u0 (
        .clk(clk), .rst_glob(rst_glob), .osc_en(osc_en),
        .cpu_clk_req(cpu_clk_req), .tst_a(tst_a), .tst_b(tst_b),
        .cpu_wr(cpu_wr), .tim_sel(tim_sel), .addr_bits(addr_bits),
        .cpu_sync_rst(cpu_sync_rst), .osc_stable(osc_stable),
        .div_hi(div_hi)
    );

    // Scoreboard: expected outputs after each rising edge.
    typedef struct packed {
        logic [W-1:0] div;
        logic         srst;
        logic         stab;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    logic [W-1:0] m_div = '0;
    logic         m_hold = 1'b0;
    logic         m_prev = 1'b0;
    int           m_st = 0;  // 0 reset, 1 settle, 2 run

    // Driver side: reference behaviour from the requirements.
    always @(posedge clk) begin
        logic flag;
        logic hit;
        flag = (tst_a ^ tst_b) | (m_div[W-1] & ~m_hold);
        if (rst_glob) begin
            m_div = '0; m_hold = 1'b0; m_prev = 1'b0; m_st = 0;
        end else begin
            hit = cpu_wr && tim_sel && (addr_bits == 2'b00);
            if (!osc_en) m_hold = 1'b0;
            else if (cpu_clk_req) m_hold = 1'b1;
            if (m_st == 0) m_st = 1;
            else if (m_st == 1 && flag) m_st = 2;
            m_div = (hit || (m_prev && !flag)) ? '0 : m_div + 1'b1;
            m_prev = flag;
        end
        exp_q.push_back('{div: m_div, srst: (m_st != 2),
                          stab: (tst_a ^ tst_b) | (m_div[W-1] & ~m_hold)});
        tag_q.push_back(cur_tag);
    end

    // Monitor side: pops and compares just after each rising edge.
    always begin
        exp_t  e;
        string t;
        @(posedge clk);
        #1;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (div_hi !== e.div || cpu_sync_rst !== e.srst || osc_stable !== e.stab) begin
                failures++;
                $display("FAIL %s scoreboard: div=%0d srst=%0b stab=%0b expected div=%0d srst=%0b stab=%0b",
                         t, div_hi, cpu_sync_rst, osc_stable, e.div, e.srst, e.stab);
            end
        end
    end

    task automatic chk(input string tag, input logic [W-1:0] ediv,
                       input logic esrst, input logic estab);
        checks++;
        if (div_hi !== ediv || cpu_sync_rst !== esrst || osc_stable !== estab) begin
            failures++;
            $display("FAIL %s: div=%0d srst=%0b stab=%0b expected div=%0d srst=%0b stab=%0b",
                     tag, div_hi, cpu_sync_rst, osc_stable, ediv, esrst, estab);
        end
    endtask

    task automatic nedge(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1 and R8: reset state, test inputs equal.
        nedge(3);
        chk("R1", 0, 1'b1, 1'b0);
        chk("R8", 0, 1'b1, 1'b0);
        cur_tag = "R7";
        rst_glob = 1'b0;
        // R7: reset held until the divider top bit rises.
        nedge(127);
        chk("R7", 127, 1'b1, 1'b0);
        nedge(1);
        chk("R7", 128, 1'b1, 1'b1);
        chk("R2", 128, 1'b1, 1'b1);
        nedge(1);
        chk("R7", 129, 1'b0, 1'b1);
        chk("R4", 129, 1'b0, 1'b1);

        // R5: writes that miss, then one that hits.
        cur_tag = "R5";
        cpu_wr = 1'b1; tim_sel = 1'b1; addr_bits = 2'b01;
        nedge(1);
        chk("R5", 130, 1'b0, 1'b1);
        tim_sel = 1'b0; addr_bits = 2'b00;
        nedge(1);
        chk("R5", 131, 1'b0, 1'b1);
        tim_sel = 1'b1;
        nedge(1);
        chk("R5", 0, 1'b0, 1'b0);
        cpu_wr = 1'b0; tim_sel = 1'b0;
        // R6: the flag dropped at the write, so one more clear follows.
        cur_tag = "R6";
        nedge(1);
        chk("R6", 0, 1'b0, 1'b0);
        nedge(1);
        chk("R4", 1, 1'b0, 1'b0);

        // R3: latch set hides the top bit; R7 reset stays released.
        cur_tag = "R3";
        nedge(127);
        chk("R7", 128, 1'b0, 1'b1);
        cpu_clk_req = 1'b1;
        nedge(1);
        chk("R3", 129, 1'b0, 1'b0);
        cpu_clk_req = 1'b0;
        nedge(1);
        chk("R6", 0, 1'b0, 1'b0);
        nedge(128);
        chk("R3", 128, 1'b0, 1'b0);
        osc_en = 1'b0;
        nedge(1);
        chk("R3", 129, 1'b0, 1'b1);
        // R3: clear wins over a simultaneous set.
        cpu_clk_req = 1'b1;
        nedge(1);
        chk("R3", 130, 1'b0, 1'b1);
        osc_en = 1'b1; cpu_clk_req = 1'b0;
        nedge(1);
        chk("R3", 131, 1'b0, 1'b1);

        // R1, R8, R2: reset with differing test inputs.
        cur_tag = "R8";
        tst_a = 1'b1; rst_glob = 1'b1;
        nedge(1);
        chk("R1", 0, 1'b1, 1'b1);
        nedge(2);
        chk("R8", 0, 1'b1, 1'b1);
        cur_tag = "R2";
        rst_glob = 1'b0;
        nedge(1);
        chk("R7", 1, 1'b1, 1'b1);
        nedge(1);
        chk("R7", 2, 1'b0, 1'b1);
        tst_b = 1'b1;
        nedge(1);
        chk("R6", 0, 1'b0, 1'b0);
        nedge(1);
        chk("R2", 1, 1'b0, 1'b0);

        nedge(2);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule